// File: doc/BRIEF.md
# Exception Priority Sequencer

This block sits between the exception sources of a small processor and its instruction sequencer. Each cycle it looks at the requests that are waiting and chooses the one to process next, using a fixed ranking. It tells the sequencer when to push an exception frame. After each exception it holds off interrupts and synchronous faults until the first instruction of the handler has retired, so the handler has a chance to mask interrupts before it can be interrupted.

Reset, bus error and breakpoint are the urgent sources. Any of them can pre-empt an exception that is still being processed or is waiting for its handler's first instruction. Trap and illegal-opcode requests are held in the block until they are granted, so none is lost while a higher-ranked exception is in service. Interrupt lines are levels, and the source holds them until it is serviced. A return-from-interrupt produces a frame-pop request, except in reset context, where no frame exists.

Top module: `exc_sequencer`

## Requirements
- R1: When several requests are live, the one processed first follows the order reset, bus error, breakpoint, interrupt, trap, illegal opcode. The remaining requests are processed one at a time afterwards. `grant` is one-hot and lasts one cycle, with bit 0=reset, 1=bus error, 2=breakpoint, 3=interrupt, 4=trap, 5=illegal. `classCode` gives the matching code: 1=reset, 2=bus error, 3=breakpoint, 4=interrupt, 5=trap, 6=illegal, and 0 when nothing is granted.
- R2: An interrupt grant carries in `irqLevel` the highest set line of `irqReq`, encoded as the bit index plus one.
- R3: `pushFrame` pulses in the same cycle as every grant except a reset grant. A reset grant never pushes a frame.
- R4: After a grant, no interrupt, trap or illegal-opcode request is granted until `stackDone` and then `firstRetired` have been seen.
- R5: A bus error, breakpoint or reset is granted at once, even while an earlier exception is being processed or is waiting for its first handler instruction.
- R6: `irqSenseEn` goes low in the grant cycle and stays low until the cycle after `firstRetired`. It is high only while the block is idle.
- R7: A single-cycle pulse on a bus-error, breakpoint, reset, trap or illegal request is held until it is granted.
- R8: A pulse on `rtiExec` produces a `popFrame` pulse one cycle later. This does not happen in reset context, which holds from block reset or from a reset grant until the next non-reset grant.
- R9: Right after block reset, `grant`, `classCode`, `pushFrame` and `popFrame` are zero and `irqSenseEn` is one.
- R10: After a reset grant the block waits for `firstRetired` without needing `stackDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| reqReset | input | 1 | Reset exception request |
| reqBusErr | input | 1 | Bus error request |
| reqBkpt | input | 1 | Breakpoint request |
| irqReq | input | NUM_IRQ | Unmasked interrupt levels, held by the source |
| reqTrap | input | 1 | Trap request |
| reqIllegal | input | 1 | Illegal opcode request |
| stackDone | input | 1 | Frame stacking finished |
| firstRetired | input | 1 | First handler instruction retired |
| rtiExec | input | 1 | Return-from-interrupt executed |
| grant | output | 6 | One-hot grant, registered |
| classCode | output | 3 | Granted class code |
| irqLevel | output | LVL_W | Level of a granted interrupt |
| pushFrame | output | 1 | Frame push request |
| popFrame | output | 1 | Frame pop request |
| irqSenseEn | output | 1 | Interrupt sensing allowed |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot;
- a push never goes with a reset grant and never appears without a grant;
- interrupt and synchronous grants come only from the idle state;
- during processing only the urgent classes can win;
- a pop always follows a return-from-interrupt.

Some behaviours depend on sequences over many cycles, and only the directed scenarios can show them:
- the order in which a mix of simultaneous requests is served;
- trap and illegal requests surviving a long bus-error service;
- a reset cutting into the wait for the first handler instruction;
- the total number of pushes and pops.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_RESET = 0;
  localparam int SRC_BUSERR = 1;
  localparam int SRC_BKPT = 2;
  localparam int SRC_IRQ = 3;
  localparam int SRC_TRAP = 4;
  localparam int SRC_ILLEGAL = 5;
  localparam logic [NUM_SRC-1:0] URGENT_MASK = 6'b000111;
  localparam logic [NUM_SRC-1:0] LATCH_MASK = 6'b110111;

  typedef enum logic [1:0] {ST_IDLE, ST_PROCESS, ST_WAIT_FIRST} seqState_t;

  typedef struct packed {
    logic urgentOnly;
    logic accept;
  } seqCtl_t;
endpackage

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_seq_pkg::*;
#(
  parameter int NUM_IRQ = 7,
  parameter int LVL_W = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic               reqReset,
  input  logic               reqBusErr,
  input  logic               reqBkpt,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               reqTrap,
  input  logic               reqIllegal,
  output logic               candValid,
  output logic               candIsReset,
  output logic [NUM_SRC-1:0] grant,
  output logic [2:0]         classCode,
  output logic [LVL_W-1:0]   irqLevel
);
  logic [NUM_SRC-1:0] pend, live, allowMask, cand, pick, clearMask;
  logic [LVL_W-1:0] topLevel;
  logic [2:0] pickCode;

  assign live = pend | {reqIllegal, reqTrap, |irqReq, reqBkpt, reqBusErr, reqReset};
  assign allowMask = ctl.urgentOnly ? URGENT_MASK : {NUM_SRC{1'b1}};
  assign cand = live & allowMask;
  assign pick = cand & (~cand + 1'b1);
  assign candValid = |cand;
  assign candIsReset = pick[SRC_RESET];
  assign clearMask = ctl.accept ? pick : '0;

  always_comb begin
    topLevel = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (irqReq[i]) topLevel = LVL_W'(i + 1);
  end

  always_comb begin
    pickCode = 3'd0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pick[i]) pickCode = 3'(i + 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
      grant <= '0;
      classCode <= '0;
      irqLevel <= '0;
    end else begin
      pend <= live & LATCH_MASK & ~clearMask;
      grant <= clearMask;
      classCode <= ctl.accept ? pickCode : 3'd0;
      irqLevel <= (ctl.accept && pick[SRC_IRQ]) ? topLevel : '0;
    end
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  assert_urgent_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.urgentOnly) |-> !(grant[SRC_IRQ] || grant[SRC_TRAP] || grant[SRC_ILLEGAL]));
endmodule

// File: rtl/exc_control.sv
module exc_control
  import exc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    candValid,
  input  logic    candIsReset,
  input  logic    stackDone,
  input  logic    firstRetired,
  input  logic    rtiExec,
  output seqCtl_t ctl,
  output logic    pushFrame,
  output logic    popFrame,
  output logic    irqSenseEn
);
  seqState_t state;
  logic curReset, resetCtx;

  assign ctl.urgentOnly = (state != ST_IDLE);
  assign ctl.accept = candValid;
  assign irqSenseEn = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curReset <= 1'b0;
      resetCtx <= 1'b1;
      pushFrame <= 1'b0;
      popFrame <= 1'b0;
    end else begin
      pushFrame <= ctl.accept && !candIsReset;
      popFrame <= rtiExec && !resetCtx;
      if (ctl.accept) begin
        state <= ST_PROCESS;
        curReset <= candIsReset;
        resetCtx <= candIsReset;
      end else begin
        unique case (state)
          ST_PROCESS:    if (curReset || stackDone) state <= ST_WAIT_FIRST;
          ST_WAIT_FIRST: if (firstRetired) state <= ST_IDLE;
          default:       state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_pop_after_rti_R8: assert property (@(posedge clk) disable iff (!rstN)
    popFrame |-> $past(rtiExec));
  assert_sense_low_on_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    pushFrame |-> !irqSenseEn);
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter int NUM_IRQ = 7,
  parameter int LVL_W = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqReset,
  input  logic               reqBusErr,
  input  logic               reqBkpt,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               reqTrap,
  input  logic               reqIllegal,
  input  logic               stackDone,
  input  logic               firstRetired,
  input  logic               rtiExec,
  output logic [5:0]         grant,
  output logic [2:0]         classCode,
  output logic [LVL_W-1:0]   irqLevel,
  output logic               pushFrame,
  output logic               popFrame,
  output logic               irqSenseEn
);
  seqCtl_t ctl;
  logic candValid, candIsReset;

  exc_datapath #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqReset(reqReset), .reqBusErr(reqBusErr), .reqBkpt(reqBkpt),
    .irqReq(irqReq), .reqTrap(reqTrap), .reqIllegal(reqIllegal),
    .candValid(candValid), .candIsReset(candIsReset),
    .grant(grant), .classCode(classCode), .irqLevel(irqLevel)
  );

  exc_control uCtl (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candIsReset(candIsReset),
    .stackDone(stackDone), .firstRetired(firstRetired), .rtiExec(rtiExec),
    .ctl(ctl), .pushFrame(pushFrame), .popFrame(popFrame), .irqSenseEn(irqSenseEn)
  );

  assert_no_push_on_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    grant[SRC_RESET] |-> !pushFrame);
  assert_push_has_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    pushFrame |-> (grant != '0 && !grant[SRC_RESET]));
  assert_low_grant_from_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (grant[SRC_IRQ] || grant[SRC_TRAP] || grant[SRC_ILLEGAL]) |-> $past(irqSenseEn));
endmodule

// File: tb/sim_exc_sequencer.sv
module sim_exc_sequencer;
  logic clk = 0, rstN = 0;
  logic reqReset = 0, reqBusErr = 0, reqBkpt = 0, reqTrap = 0, reqIllegal = 0;
  logic [6:0] irqReq = '0;
  logic stackDone = 0, firstRetired = 0, rtiExec = 0;
  logic [5:0] grant;
  logic [2:0] classCode, irqLevel;
  logic pushFrame, popFrame, irqSenseEn;
  int nChecks = 0, nFails = 0, pushCnt = 0, popCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_sequencer u0 (.*);

  always @(negedge clk) if (rstN) begin
    pushCnt += int'(pushFrame);
    popCnt += int'(popFrame);
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finishHandler();
    stackDone = 1; step(); stackDone = 0;
    firstRetired = 1; step(); firstRetired = 0;
  endtask

  task automatic tReset();
    chk("R9 grant", grant, 0); chk("R9 class", classCode, 0);
    chk("R9 push", pushFrame, 0); chk("R9 pop", popFrame, 0);
    chk("R9 sense", irqSenseEn, 1);
    rtiExec = 1; step(); rtiExec = 0;
    chk("R8 no pop after block reset", popFrame, 0);
  endtask

  task automatic tBusAndIrq();
    reqBusErr = 1; irqReq = 7'b0010010; step(); reqBusErr = 0;
    chk("R1 bus before irq", grant, 6'b000010); chk("R1 class bus", classCode, 2);
    chk("R3 push bus", pushFrame, 1); chk("R6 sense low", irqSenseEn, 0);
    step(); chk("R1 single-cycle grant", grant, 0);
    stackDone = 1; step(); stackDone = 0; step();
    chk("R4 irq held in wait", grant, 0); chk("R6 sense low wait", irqSenseEn, 0);
    firstRetired = 1; step(); firstRetired = 0;
    chk("R6 sense high after retire", irqSenseEn, 1);
    step();
    chk("R1 irq next", grant, 6'b001000); chk("R1 class irq", classCode, 4);
    chk("R2 level 5", irqLevel, 5); chk("R3 push irq", pushFrame, 1);
    irqReq = '0; finishHandler();
    rtiExec = 1; step(); rtiExec = 0;
    chk("R8 pop after rti", popFrame, 1);
  endtask

  task automatic tBkptDuringIrq();
    irqReq = 7'b0000001; step(); irqReq = '0;
    chk("R2 level 1", irqLevel, 1);
    step();
    reqBkpt = 1; step(); reqBkpt = 0;
    chk("R5 bkpt preempts", grant, 6'b000100); chk("R5 class bkpt", classCode, 3);
    chk("R3 push bkpt", pushFrame, 1);
    finishHandler(); step();
    chk("R7 nothing stale", grant, 0);
  endtask

  task automatic tIrqDuringBus();
    reqBusErr = 1; step(); reqBusErr = 0;
    chk("R5 bus grant", grant, 6'b000010);
    irqReq = 7'b1000000; step();
    chk("R4 irq not sensed", grant, 0); chk("R6 sense low", irqSenseEn, 0);
    stackDone = 1; step(); stackDone = 0; step();
    chk("R4 irq blocked wait", grant, 0);
    firstRetired = 1; step(); firstRetired = 0; step();
    chk("R4 irq after retire", grant, 6'b001000); chk("R2 level 7", irqLevel, 7);
    irqReq = '0; finishHandler();
  endtask

  task automatic tSyncLatched();
    reqBusErr = 1; step(); reqBusErr = 0;
    chk("R1 bus", grant, 6'b000010);
    reqTrap = 1; reqIllegal = 1; step(); reqTrap = 0; reqIllegal = 0;
    chk("R7 sync held off", grant, 0);
    finishHandler(); step();
    chk("R7 trap survives", grant, 6'b010000); chk("R1 class trap", classCode, 5);
    step(); chk("R4 illegal waits", grant, 0);
    finishHandler(); step();
    chk("R7 illegal survives", grant, 6'b100000); chk("R1 class illegal", classCode, 6);
    finishHandler();
  endtask

  task automatic tResetInWait();
    reqTrap = 1; step(); reqTrap = 0;
    chk("R1 trap", grant, 6'b010000);
    stackDone = 1; step(); stackDone = 0;
    reqReset = 1; step(); reqReset = 0;
    chk("R5 reset preempts", grant, 6'b000001); chk("R1 class reset", classCode, 1);
    chk("R3 no push reset", pushFrame, 0); chk("R6 sense low", irqSenseEn, 0);
    step();
    firstRetired = 1; step(); firstRetired = 0;
    chk("R10 idle without stackDone", irqSenseEn, 1);
    rtiExec = 1; step(); rtiExec = 0;
    chk("R8 no pop in reset ctx", popFrame, 0);
  endtask

  initial begin
    #1; chk("R9 sense during reset", irqSenseEn, 1);
    repeat (3) @(posedge clk);
    #1; rstN = 1; step();
    tReset();
    tBusAndIrq();
    tBkptDuringIrq();
    tIrqDuringBus();
    tSyncLatched();
    tResetInWait();
    step();
    chk("R3 push total", pushCnt, 10);
    chk("R8 pop total", popCnt, 1);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule